// File: doc/BRIEF.md
# Byte Permute and Align Unit

This block moves data at byte granularity across a 128-bit datapath. It has two operations. The first is a byte funnel shift. Operand A is placed above operand B, and the joined value is shifted toward the low end by an immediate count of whole bytes. The low part of the shifted value is kept. The second is a per-byte table lookup. Each output byte takes its source index from the matching byte of operand B and copies the indexed byte of operand A. A flag bit in that control byte can force the output byte to zero instead.

A narrow mode runs either operation on the low 8 bytes of each operand. In narrow mode the upper 64 bits of the result are zero. Each accepted operation is registered once. The result appears with `out_valid` on the cycle after `in_valid`, and it holds between operations. This makes the unit suitable for a one-stage slot in a vector execution pipeline.

Top module: `bytemove_unit`

## Requirements
- R1: While reset is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high in exactly the cycles that follow a cycle in which `in_valid` was sampled high.
- R3: When `in_valid` is low, `out_data` keeps its previous value.
- R4: With `op_sel`=0 (align) and `narrow`=0, the result is the low 128 bits of the 256-bit value {opa, opb} shifted right by 8×`shamt` bits, with zeros entering from the top.
- R5: In wide align, any `shamt` of 32 or more gives an all-zero result.
- R6: With `op_sel`=0 and `narrow`=1, result bits [63:0] are the low 64 bits of {opa[63:0], opb[63:0]} shifted right by 8×`shamt`. A `shamt` of 16 or more gives zero. Result bits [127:64] are zero.
- R7: With `op_sel`=1 (shuffle) and `narrow`=0, control byte i is opb[8i+7:8i]. If bit 7 of control byte i is 1, result byte i is zero. Otherwise result byte i is byte number (bits [3:0] of the control byte) of opa.
- R8: In shuffle, bits [6:4] of every control byte have no effect on the result.
- R9: With `op_sel`=1 and `narrow`=1, result bytes 0 to 7 follow R7, except that only control bits [2:0] select among opa bytes 0 to 7. Control bit 3 and opb[127:64] are ignored, and result bits [127:64] are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op_sel | input | 1 | 0 = byte align (funnel shift), 1 = byte shuffle |
| narrow | input | 1 | 1 = operate on 8-byte operands |
| shamt | input | 6 | Align shift amount in bytes |
| opa | input | 128 | High half for align; data bytes for shuffle |
| opb | input | 128 | Low half for align; control bytes for shuffle |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 128 | Registered result |

## Verification
The assertions assume the inputs are known (not X) whenever `in_valid` is high, and they read `op_sel`, `narrow` and `shamt` only on accepted cycles. The checks that relate a result to its operands through `$past` further assume the operands are sampled on the same edge that launches the result. The stimulus changes inputs only on the falling clock edge and drives defined values from reset release onward. It also changes the operands while `in_valid` is low, to show that idle cycles leave the registered result alone.

// File: rtl/bm_pkg.sv
package bm_pkg;

    // Default geometry: 16 byte lanes of 8 bits
    localparam int BM_LANES  = 16;
    localparam int BM_BYTE_W = 8;

    typedef enum logic {
        BM_OP_ALIGN   = 1'b0,
        BM_OP_SHUFFLE = 1'b1
    } bm_op_e;

endpackage

// File: rtl/bm_align_shift.sv
// Byte funnel shifter: {hi, lo} >> (8 * shamt), low lanes kept.
module bm_align_shift #(
    parameter int LANES   = 16,
    parameter int BYTE_W  = 8,
    parameter int SHAMT_W = 6,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic [DATA_W-1:0]  hi,
    input  logic [DATA_W-1:0]  lo,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               narrow,
    output logic [DATA_W-1:0]  result
);
    localparam int HALF  = LANES / 2;
    localparam int CAT   = 2 * LANES;
    localparam int CAT_W = $clog2(CAT);
    localparam int SUM_W = ((SHAMT_W > CAT_W) ? SHAMT_W : CAT_W) + 1;

    logic [BYTE_W-1:0] cat_wide [CAT];
    logic [BYTE_W-1:0] cat_nar  [CAT];

    // Concatenated byte views for both widths
    for (genvar k = 0; k < CAT; k++) begin : g_cat
        if (k < HALF) begin : g_low
            assign cat_wide[k] = lo[k*BYTE_W +: BYTE_W];
            assign cat_nar[k]  = lo[k*BYTE_W +: BYTE_W];
        end else if (k < LANES) begin : g_mid
            assign cat_wide[k] = lo[k*BYTE_W +: BYTE_W];
            assign cat_nar[k]  = hi[(k-HALF)*BYTE_W +: BYTE_W];
        end else begin : g_top
            assign cat_wide[k] = hi[(k-LANES)*BYTE_W +: BYTE_W];
            assign cat_nar[k]  = '0;
        end
    end

    // One selector per output lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SUM_W-1:0]  src;
        logic [BYTE_W-1:0] wide_b;
        logic [BYTE_W-1:0] nar_b;

        assign src    = SUM_W'(shamt) + SUM_W'(i);
        assign wide_b = (src < SUM_W'(CAT)) ? cat_wide[src[CAT_W-1:0]] : '0;

        if (i < HALF) begin : g_nar_live
            assign nar_b = (src < SUM_W'(LANES)) ? cat_nar[src[CAT_W-1:0]] : '0;
        end else begin : g_nar_zero
            assign nar_b = '0;
        end

        assign result[i*BYTE_W +: BYTE_W] = narrow ? nar_b : wide_b;
    end

endmodule

// File: rtl/bm_byte_shuffle.sv
// Per-lane byte lookup with a zero-forcing flag in the control MSB.
module bm_byte_shuffle #(
    parameter int LANES   = 16,
    parameter int BYTE_W  = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] ctrl,
    input  logic              narrow,
    output logic [DATA_W-1:0] result
);
    localparam int HALF  = LANES / 2;
    localparam int IDX_W = $clog2(LANES);

    logic [BYTE_W-1:0] src_b [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_src
        assign src_b[k] = data[k*BYTE_W +: BYTE_W];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] ctl;
        logic              zero_flag;
        logic [IDX_W-1:0]  sel_wide;
        logic [IDX_W-1:0]  sel_nar;
        logic [BYTE_W-1:0] wide_b;
        logic [BYTE_W-1:0] nar_b;
        logic              unused_resv;

        assign ctl         = ctrl[i*BYTE_W +: BYTE_W];
        assign zero_flag   = ctl[BYTE_W-1];
        assign sel_wide    = ctl[IDX_W-1:0];
        assign sel_nar     = {1'b0, ctl[IDX_W-2:0]};
        // Reserved control bits between the index and the flag
        assign unused_resv = ^ctl[BYTE_W-2:IDX_W];

        assign wide_b = zero_flag ? '0 : src_b[sel_wide];

        if (i < HALF) begin : g_nar_live
            assign nar_b = zero_flag ? '0 : src_b[sel_nar];
        end else begin : g_nar_zero
            assign nar_b = '0;
        end

        assign result[i*BYTE_W +: BYTE_W] = narrow ? nar_b : wide_b;
    end

endmodule

// File: rtl/bytemove_unit.sv
module bytemove_unit
    import bm_pkg::*;
#(
    parameter int LANES    = BM_LANES,
    parameter int BYTE_W   = BM_BYTE_W,
    localparam int DATA_W  = LANES * BYTE_W,
    localparam int SHAMT_W = $clog2(LANES) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               op_sel,
    input  logic               narrow,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t            stage_d;
    stage_t            stage_q;
    bm_op_e            op;
    logic [DATA_W-1:0] align_res;
    logic [DATA_W-1:0] shuf_res;

    assign op = bm_op_e'(op_sel);

    bm_align_shift #(
        .LANES   (LANES),
        .BYTE_W  (BYTE_W),
        .SHAMT_W (SHAMT_W)
    ) u_align (
        .hi     (opa),
        .lo     (opb),
        .shamt  (shamt),
        .narrow (narrow),
        .result (align_res)
    );

    bm_byte_shuffle #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_shuf (
        .data   (opa),
        .ctrl   (opb),
        .narrow (narrow),
        .result (shuf_res)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.data = (op == BM_OP_SHUFFLE) ? shuf_res : align_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign out_data  = stage_q.data;

endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
    parameter int LANES    = 16,
    parameter int BYTE_W   = 8,
    localparam int DATA_W  = LANES * BYTE_W,
    localparam int SHAMT_W = $clog2(LANES) + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               op_sel,
    input logic               narrow,
    input logic [SHAMT_W-1:0] shamt,
    input logic [DATA_W-1:0]  opa,
    input logic [DATA_W-1:0]  opb,
    input logic               out_valid,
    input logic [DATA_W-1:0]  out_data
);
    localparam int HALF_W = DATA_W / 2;

    logic all_flags;
    always_comb begin
        all_flags = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            all_flags = all_flags & opb[i*BYTE_W + BYTE_W - 1];
        end
    end

    logic opa_seen;
    assign opa_seen = ^opa;

    // R1: coming out of reset the output is idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && out_data == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    assert_zero_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && !narrow && shamt == '0) |=> (out_data == $past(opb)));

    assert_big_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && !narrow && shamt >= SHAMT_W'(2*LANES)) |=> (out_data == '0));

    assert_narrow_align_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && narrow) |=> (out_data[DATA_W-1:HALF_W] == '0));

    assert_all_flags_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && !narrow && all_flags && (opa_seen || !opa_seen)) |=> (out_data == '0));

    assert_narrow_shuf_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && narrow) |=> (out_data[DATA_W-1:HALF_W] == '0));

endmodule

bind bytemove_unit bm_checker #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .narrow    (narrow),
    .shamt     (shamt),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_bytemove_unit.sv
module sim_bytemove_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    localparam logic [127:0] PA = 128'h1F1E1D1C1B1A19181716151413121110;
    localparam logic [127:0] PB = 128'h0F0E0D0C0B0A09080706050403020100;

    typedef struct packed {
        logic         op;
        logic         nar;
        logic [5:0]   sh;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 6'd0,  PA, PB, PB},                                          // R4
        '{1'b0, 1'b0, 6'd16, PA, PB, PA},                                          // R4
        '{1'b0, 1'b0, 6'd5,  PA, PB, 128'h14131211100F0E0D0C0B0A0908070605},       // R4
        '{1'b0, 1'b0, 6'd31, PA, PB, 128'h1F},                                     // R4
        '{1'b0, 1'b0, 6'd32, PA, PB, 128'h0},                                      // R5
        '{1'b0, 1'b0, 6'd63, PA, PB, 128'h0},                                      // R5
        '{1'b0, 1'b1, 6'd3,  PA, PB, 128'h1211100706050403},                       // R6
        '{1'b0, 1'b1, 6'd8,  PA, PB, 128'h1716151413121110},                       // R6
        '{1'b0, 1'b1, 6'd16, PA, PB, 128'h0},                                      // R6
        '{1'b1, 1'b0, 6'd0,  PA, 128'h000102030405060708090A0B0C0D0E0F,
                             128'h101112131415161718191A1B1C1D1E1F},               // R7
        '{1'b1, 1'b0, 6'd9,  PA, {16{8'h80}}, 128'h0},                             // R7
        '{1'b1, 1'b0, 6'd0,  PA, 128'h7F7E7D7C7B7A79787776757473727170, PA},       // R8
        '{1'b1, 1'b0, 6'd0,  PA, {8{16'h0383}},
                             128'h13001300130013001300130013001300},               // R7
        '{1'b1, 1'b1, 6'd0,  PA, {64'hFFFFFFFFFFFFFFFF, 64'h08090A0B0C0D0E0F},
                             128'h1011121314151617},                               // R9
        '{1'b1, 1'b1, 6'd0,  PA, {64'h0, 64'h7F7E7D7C7B7A7978},
                             128'h1716151413121110}                                // R9, R8
    };

    logic         clk;
    logic         rst_n;
    logic         in_valid;
    logic         op_sel;
    logic         narrow;
    logic [5:0]   shamt;
    logic [127:0] opa;
    logic [127:0] opb;
    logic         out_valid;
    logic [127:0] out_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    bytemove_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .narrow    (narrow),
        .shamt     (shamt),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input vec_t t);
        in_valid = v;
        op_sel   = t.op;
        narrow   = t.nar;
        shamt    = t.sh;
        opa      = t.a;
        opb      = t.b;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        op_sel   = 1'b0;
        narrow   = 1'b0;
        shamt    = '0;
        opa      = '0;
        opb      = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {127'b0, out_valid}, 128'h0);
        chk("R1 data in reset", out_data, 128'h0);
        rst_n = 1'b1;

        // Table walk, back-to-back operations
        drive(1'b1, VECS[0]);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            chk($sformatf("R2 valid vec %0d", i), {127'b0, out_valid}, 128'h1);
            chk($sformatf("R4-R9 table vec %0d", i), out_data, VECS[i].exp);
            if (i + 1 < NVEC) drive(1'b1, VECS[i+1]);
            else              in_valid = 1'b0;
        end

        // R2: valid drops one cycle after in_valid falls
        held = out_data;
        @(negedge clk);
        chk("R2 valid low when idle", {127'b0, out_valid}, 128'h0);

        // R3: operands change while idle, result holds
        opa    = ~PA;
        opb    = ~PB;
        op_sel = 1'b0;
        shamt  = 6'd1;
        repeat (3) @(negedge clk);
        chk("R3 data held while idle", out_data, held);

        // R8: reserved bits alone differ, same result as plain index
        drive(1'b1, '{1'b1, 1'b0, 6'd0, PA, 128'h0F0E0D0C0B0A09080706050403020100, 128'h0});
        @(negedge clk);
        chk("R8 plain index", out_data, PA);
        opb = 128'h3F4E5D6C7B0A19282736454413627150;
        @(negedge clk);
        chk("R8 reserved bits set", out_data, PA);

        // R9: narrow shuffle ignores opa upper half
        drive(1'b1, '{1'b1, 1'b1, 6'd0, {64'hDEADBEEFCAFEF00D, PA[63:0]},
                      {64'hAAAAAAAAAAAAAAAA, 64'h0001020304050607}, 128'h0});
        @(negedge clk);
        chk("R9 narrow reverse", out_data, 128'h1011121314151617);

        // R6: narrow align ignores upper halves
        drive(1'b1, '{1'b0, 1'b1, 6'd15, {64'hFFFFFFFFFFFFFFFF, PA[63:0]},
                      {64'hFFFFFFFFFFFFFFFF, PB[63:0]}, 128'h0});
        @(negedge clk);
        chk("R6 narrow shift 15", out_data, 128'h17);
        in_valid = 1'b0;

        // R1: reset in mid-run clears the output
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 valid after re-reset", {127'b0, out_valid}, 128'h0);
        chk("R1 data after re-reset", out_data, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule